// File: doc/BRIEF.md
# UART Receive Character Queue with Idle Timeout

This block sits between a UART's serial deserializer and the host read port. Each received character arrives as a one-cycle valid strobe together with its byte and three error tags. Byte and tags are kept as one 11-bit entry in a queue of up to 64 entries. The host always sees the oldest entry: its byte on the read-data port and its three tags on the head-status port. A read strobe retires that entry, and the next entry appears on the following cycle. When queue mode is off, the storage behaves as a single holding register with room for one character.

Two interrupt sources serve the host. The level interrupt asserts while the number of stored characters is at or above a programmable trigger. The idle timeout asserts when characters are waiting and nothing has been written or read for a window measured in bit-time ticks. That window is four character lengths plus twelve bit times. The character length is derived from the word-length code, the parity enable and the stop-bit setting. A character that arrives when there is no room is dropped and raises a sticky overrun flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the stored count is 0 and data_ready, overrun, rx_irq and tmo_irq are all 0.
- R2: Entries leave in arrival order. rd_data shows the head byte, and head_err shows that same entry's three tags with rx_err bit i on head_err bit i. After a read, the next entry's byte and tags are visible on the following cycle.
- R3: With fifo_en=1 the queue holds 64 entries. A character that arrives at 64 entries is dropped, and the stored count and contents stay unchanged.
- R4: With fifo_en=0 the capacity is one entry. A second character that arrives before a read is dropped and the first character stays at the head.
- R5: Dropping a character sets overrun. overrun stays set until an ovr_clr strobe, and a drop in the same cycle as ovr_clr leaves it set.
- R6: A read strobe while the queue is empty has no effect. The count stays 0.
- R7: A write and a read in the same cycle on a non-empty queue that is not full leave the count unchanged, advance the head, and append the new entry at the tail. At full capacity, a write in the same cycle as a read is still dropped: the count falls by one and overrun is set.
- R8: rx_irq equals rxint_en AND (count >= trigger). The trigger is trig_level with fifo_en=1, with 0 treated as 1. The trigger is 1 with fifo_en=0.
- R9: The character length is 1 + (5 + word_len) + parity_en + (1 + stop2) bits, with word_len 00..11 giving 5..8 data bits. tmo_irq asserts once 4 × length + 12 bit_tick pulses have passed with no accepted write and no read, provided the queue is non-empty and rxint_en=1. After one pulse fewer it is still 0.
- R10: An accepted write or a read restarts the timeout count. A read deasserts tmo_irq on the next cycle.
- R11: tmo_irq is 0 whenever the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Error tags of the received byte |
| bit_tick | input | 1 | One pulse per serial bit time |
| word_len | input | 2 | Data bits code: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | Parity bit present in each character |
| stop2 | input | 1 | Two stop bits instead of one |
| fifo_en | input | 1 | 1: 64-entry queue; 0: single holding register |
| rxint_en | input | 1 | Enables rx_irq and tmo_irq |
| trig_level | input | 7 | Fill trigger for rx_irq |
| rd_en | input | 1 | Host read strobe, retires the head entry |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Byte of the head entry |
| head_err | output | 3 | Error tags of the head entry |
| data_ready | output | 1 | At least one entry stored |
| overrun | output | 1 | Sticky: a character was dropped |
| fill_level | output | 7 | Number of stored entries |
| rx_irq | output | 1 | Fill level at or above trigger |
| tmo_irq | output | 1 | Idle timeout with data waiting |

## Verification
A character strobe and a host read can land in the same cycle, and the outcome depends on how full the queue is. The bench provokes this on a partly filled queue, where the count must stay put while the head moves to the second entry. It provokes it again at exactly 64 entries, where the new character must be dropped with overrun set while the count drops to 63. The timeout restart is also driven by a write arriving partway through a window. The bench judges it by tmo_irq staying low until a full fresh window has elapsed, for every one of the sixteen character formats.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    typedef struct packed {
        logic [ERR_W-1:0]  err;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // Bits per serial character: start, data, optional parity, one or two stops.
    function automatic int char_bits(input logic [1:0] wl, input logic par, input logic s2);
        return 1 + (5 + int'(wl)) + int'(par) + 1 + int'(s2);
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  rx_entry_t        push_entry,
    output rx_entry_t        head_entry,
    output logic [LVL_W-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [LVL_W-1:0] cnt;
    } store_st_t;

    store_st_t st_d, st_q;
    rx_entry_t mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wptr = bump(st_q.wptr);
        if (pop)  st_d.rptr = bump(st_q.rptr);
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wptr] <= push_entry;
    end

    assign head_entry = mem[st_q.rptr];
    assign level      = st_q.cnt;

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active || restart)
            st_d.cnt = '0;
        else if (tick && (st_q.cnt < limit))
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = active && (st_q.cnt >= limit);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_fifo_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int TMO_CHARS = 4,
    parameter int TMO_EXTRA = 12,
    parameter int CNT_W     = 8,
    parameter int LVL_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [ERR_W-1:0]  rx_err,
    input  logic              bit_tick,
    input  logic [1:0]        word_len,
    input  logic              parity_en,
    input  logic              stop2,
    input  logic              fifo_en,
    input  logic              rxint_en,
    input  logic [LVL_W-1:0]  trig_level,
    input  logic              rd_en,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [ERR_W-1:0]  head_err,
    output logic              data_ready,
    output logic              overrun,
    output logic [LVL_W-1:0]  fill_level,
    output logic              rx_irq,
    output logic              tmo_irq
);

    typedef struct packed {
        logic ovr;
    } ctl_st_t;

    ctl_st_t          ctl_d, ctl_q;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] cap;
    logic [LVL_W-1:0] trig_eff;
    logic [CNT_W-1:0] tmo_limit;
    logic             full, push, pop, nonempty, expired;
    rx_entry_t        in_entry, head;

    always_comb begin
        cap      = fifo_en ? LVL_W'(DEPTH) : LVL_W'(1);
        full     = (level >= cap);
        nonempty = (level != '0);
        push     = rx_valid && !full;
        pop      = rd_en && nonempty;

        ctl_d     = ctl_q;
        ctl_d.ovr = (rx_valid && full) || (ctl_q.ovr && !ovr_clr);

        if (!fifo_en || (trig_level == '0)) trig_eff = LVL_W'(1);
        else                                 trig_eff = trig_level;

        tmo_limit = CNT_W'(TMO_CHARS * char_bits(word_len, parity_en, stop2) + TMO_EXTRA);

        in_entry.data = rx_data;
        in_entry.err  = rx_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rxf_store #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .pop        (pop),
        .push_entry (in_entry),
        .head_entry (head),
        .level      (level)
    );

    rxf_timeout #(.CNT_W(CNT_W)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (bit_tick),
        .restart (push || pop),
        .active  (nonempty),
        .limit   (tmo_limit),
        .expired (expired)
    );

    assign rd_data    = head.data;
    assign head_err   = head.err;
    assign data_ready = nonempty;
    assign overrun    = ctl_q.ovr;
    assign fill_level = level;
    assign rx_irq     = rxint_en && (level >= trig_eff);
    assign tmo_irq    = rxint_en && expired && nonempty;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rd_en,
    input logic             ovr_clr,
    input logic             fifo_en,
    input logic             rxint_en,
    input logic [LVL_W-1:0] fill_level,
    input logic             overrun,
    input logic             rx_irq,
    input logic             tmo_irq
);

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    a_r4_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && fill_level != '0 && rx_valid) |=> overrun);

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && rd_en && !rx_valid) |=> (fill_level == '0));

    a_r7_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && fill_level != '0 && fill_level < LVL_W'(DEPTH) && rd_en && rx_valid)
        |=> $stable(fill_level));

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq || tmo_irq) |-> rxint_en);

    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill_level != '0) |=> !tmo_irq);

    a_r11_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> !tmo_irq);

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rd_en      (rd_en),
    .ovr_clr    (ovr_clr),
    .fifo_en    (fifo_en),
    .rxint_en   (rxint_en),
    .fill_level (fill_level),
    .overrun    (overrun),
    .rx_irq     (rx_irq),
    .tmo_irq    (tmo_irq)
);

// File: tb/uart_rx_fifo_test.sv
module uart_rx_fifo_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic       bit_tick = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       parity_en = 1'b0;
    logic       stop2 = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rxint_en = 1'b1;
    logic [6:0] trig_level = 7'd16;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] head_err;
    logic       data_ready, overrun, rx_irq, tmo_irq;
    logic [6:0] fill_level;

    int vectors = 0;
    int bad     = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    uart_rx_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .bit_tick(bit_tick), .word_len(word_len),
        .parity_en(parity_en), .stop2(stop2), .fifo_en(fifo_en),
        .rxint_en(rxint_en), .trig_level(trig_level), .rd_en(rd_en),
        .ovr_clr(ovr_clr), .rd_data(rd_data), .head_err(head_err),
        .data_ready(data_ready), .overrun(overrun), .fill_level(fill_level),
        .rx_irq(rx_irq), .tmo_irq(tmo_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic [7:0] d, input logic [2:0] e,
                       input logic rd, input logic tk, input logic oc);
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_err = e; rd_en = rd; bit_tick = tk; ovr_clr = oc;
        @(posedge clk);
        #1;
        rx_valid = 1'b0; rd_en = 1'b0; bit_tick = 1'b0; ovr_clr = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            bad++;
            vectors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 level", int'(fill_level), 0);
        chk("R1 ready", int'(data_ready), 0);
        chk("R1 ovr", int'(overrun), 0);
        chk("R1 irq", int'(rx_irq), 0);
        chk("R1 tmo", int'(tmo_irq), 0);
        rst_n = 1'b1;

        // R6: read while empty
        cyc(0, 0, 0, 1, 0, 0);
        chk("R6 empty read", int'(fill_level), 0);

        // R3/R8/R2: fill to 64, watching the level interrupt
        trig_level = 7'd16;
        for (int i = 0; i < 64; i++) begin
            cyc(1, pat(i), 3'(i % 8), 0, 0, 0);
            chk("R3 level", int'(fill_level), i + 1);
            chk("R8 rx_irq", int'(rx_irq), (i + 1 >= 16) ? 1 : 0);
        end
        trig_level = 7'd0;
        #1 chk("R8 trig0", int'(rx_irq), 1);
        rxint_en = 1'b0;
        #1 chk("R8 gated", int'(rx_irq), 0);
        rxint_en = 1'b1;
        trig_level = 7'd64;
        #1 chk("R8 trig64", int'(rx_irq), 1);
        cyc(1, 8'hEE, 3'd7, 0, 0, 0);
        chk("R3 drop level", int'(fill_level), 64);
        chk("R5 ovr set", int'(overrun), 1);
        cyc(0, 0, 0, 0, 0, 0);
        chk("R5 sticky", int'(overrun), 1);
        cyc(1, 8'hEE, 3'd7, 0, 0, 1);
        chk("R5 set wins", int'(overrun), 1);
        cyc(0, 0, 0, 0, 0, 1);
        chk("R5 clear", int'(overrun), 0);
        // R7: simultaneous write and read while full -> drop
        cyc(1, 8'hEE, 3'd7, 1, 0, 0);
        chk("R7 full simul level", int'(fill_level), 63);
        chk("R7 full simul ovr", int'(overrun), 1);
        cyc(0, 0, 0, 0, 0, 1);
        // R2: drain in order (entry 0 already retired)
        for (int i = 1; i < 64; i++) begin
            chk("R2 data", int'(rd_data), int'(pat(i)));
            chk("R2 err", int'(head_err), i % 8);
            cyc(0, 0, 0, 1, 0, 0);
        end
        chk("R2 drained", int'(fill_level), 0);
        chk("R2 ready", int'(data_ready), 0);

        // R7: simultaneous write and read, not full
        cyc(1, 8'h11, 3'd1, 0, 0, 0);
        cyc(1, 8'h22, 3'd2, 0, 0, 0);
        cyc(1, 8'h33, 3'd4, 1, 0, 0);
        chk("R7 level", int'(fill_level), 2);
        chk("R7 head", int'(rd_data), 8'h22);
        chk("R7 head err", int'(head_err), 2);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R7 tail", int'(rd_data), 8'h33);
        chk("R7 tail err", int'(head_err), 4);
        cyc(0, 0, 0, 1, 0, 0);

        // R4: single holding register
        fifo_en = 1'b0;
        trig_level = 7'd20;
        cyc(1, 8'hA5, 3'd5, 0, 0, 0);
        chk("R4 level", int'(fill_level), 1);
        chk("R8 single trig", int'(rx_irq), 1);
        cyc(1, 8'h5A, 3'd2, 0, 0, 0);
        chk("R4 drop level", int'(fill_level), 1);
        chk("R4 head kept", int'(rd_data), 8'hA5);
        chk("R4 ovr", int'(overrun), 1);
        cyc(0, 0, 0, 1, 0, 1);
        chk("R4 empty", int'(fill_level), 0);
        fifo_en = 1'b1;

        // R9/R10/R11: timeout window for every character format
        for (int w = 0; w < 4; w++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++) begin
                    int lim;
                    word_len = 2'(w); parity_en = p[0]; stop2 = s[0];
                    lim = 4 * (1 + 5 + w + p + 1 + s) + 12;
                    for (int k = 0; k < lim + 3; k++) cyc(0, 0, 0, 0, 1, 0);
                    chk("R11 empty no tmo", int'(tmo_irq), 0);
                    cyc(1, 8'h77, 3'd0, 0, 0, 0);
                    // R10: a write partway through restarts the window
                    for (int k = 0; k < lim - 5; k++) cyc(0, 0, 0, 0, 1, 0);
                    cyc(1, 8'h78, 3'd0, 0, 0, 0);
                    for (int k = 1; k <= lim; k++) begin
                        cyc(0, 0, 0, 0, 1, 0);
                        if (k == lim - 1) chk("R10 restart low", int'(tmo_irq), 0);
                        if (k == lim)     chk("R9 tmo high", int'(tmo_irq), 1);
                    end
                    rxint_en = 1'b0;
                    #1 chk("R9 gated", int'(tmo_irq), 0);
                    rxint_en = 1'b1;
                    cyc(0, 0, 0, 1, 0, 0);
                    chk("R10 read clears", int'(tmo_irq), 0);
                    cyc(0, 0, 0, 1, 0, 0);
                    chk("R11 empty", int'(fill_level), 0);
                end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

endmodule